// File: doc/BRIEF.md
# Power Mode and Clock Controller

This block manages the clock and power state of a small microcontroller core. While the core runs, a select bit and a divider code together choose between a fast clock from a high-speed oscillator and a slow clock from a low-speed oscillator. A change of source takes effect only once the target oscillator reports that it is stable. Until then the old source stays in use and a pending flag shows that a switch is waiting.

A halt strobe moves the core into one of three low-power states. Which one depends on an idle-enable bit and a keep-system-clock bit. Each state keeps a different set of clock domains running. On entry the block pulses a watchdog clear, sets a power-down flag and clears the watchdog-timeout flag. A wake-up strobe returns the core to the run mode that was active before the halt.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the controller reports the following:
  - mode 0 (normal, fast source), with `sys_src_hi_o`=1 and `switch_pend_o`=0;
  - `pdf_o`=0 and `to_flag_o`=0, with `wdt_clr_o`=0;
  - all three clock enables at 1.
- R2: In run, the requested mode is slow (code 1) exactly when `hl_sel_i`=0 and `div_sel_i` is 000 or 001. Every other combination requests normal (code 0).
- R3: A switch from normal to slow completes at the first clock edge that samples `losc_stable_i`=1. Before that edge, `mode_o` stays 0, `sys_src_hi_o` stays 1 and `switch_pend_o` reads 1.
- R4: A switch from slow to normal completes at the first clock edge that samples `hosc_stable_i`=1. Before that edge, `mode_o` stays 1, `sys_src_hi_o` stays 0 and `switch_pend_o` reads 1.
- R5: A halt taken with `idle_en_i`=0 enters sleep (mode code 2). In sleep, `sys_clk_en_o`=0, `tb_clk_en_o`=0 and `sub_clk_en_o`=1.
- R6: A halt taken with `idle_en_i`=1 and `sys_on_idle_i`=0 enters idle0 (mode code 3). In idle0, `sys_clk_en_o`=0, `tb_clk_en_o`=1 and `sub_clk_en_o`=1.
- R7: A halt taken with `idle_en_i`=1 and `sys_on_idle_i`=1 enters idle1 (mode code 4). In idle1, all three clock enables are 1.
- R8: Entering any low-power state raises `wdt_clr_o` for exactly one cycle. In the same cycle `pdf_o` reads 1 and `to_flag_o` reads 0.
- R9: `wake_i` in a low-power state returns the controller to the run mode held before the halt (code 0 or 1), with system and time-base clocks enabled. `pdf_o` is kept.
- R10: In a low-power state, further halt strobes and changes of the select inputs are ignored: `mode_o` and `sys_src_hi_o` hold. `wake_i` in run has no effect.
- R11: `wdt_timeout_i` sets `to_flag_o`, and `flag_clr_i` clears both `pdf_o` and `to_flag_o`. A halt entry in the same cycle takes priority: `pdf_o`=1 and `to_flag_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hl_sel_i | input | 1 | High/low clock select bit |
| div_sel_i | input | 3 | Clock divider code |
| idle_en_i | input | 1 | Halt goes to an idle state instead of sleep |
| sys_on_idle_i | input | 1 | Keep the system clock on during idle |
| hosc_stable_i | input | 1 | High-speed oscillator stable |
| losc_stable_i | input | 1 | Low-speed oscillator stable |
| halt_i | input | 1 | Halt request strobe |
| wake_i | input | 1 | Wake-up strobe |
| wdt_timeout_i | input | 1 | Watchdog timeout event |
| flag_clr_i | input | 1 | Clear power-down and timeout flags |
| mode_o | output | 3 | 0 normal, 1 slow, 2 sleep, 3 idle0, 4 idle1 |
| switch_pend_o | output | 1 | Source switch waiting for oscillator stability |
| sys_src_hi_o | output | 1 | System clock taken from the high-speed source |
| sys_clk_en_o | output | 1 | System clock gate enable |
| tb_clk_en_o | output | 1 | Time-base clock gate enable |
| sub_clk_en_o | output | 1 | Sub clock gate enable |
| wdt_clr_o | output | 1 | One-cycle watchdog clear pulse |
| pdf_o | output | 1 | Power-down flag |
| to_flag_o | output | 1 | Watchdog timeout flag |

## Verification
Every result is registered, so each output is due exactly one clock edge after the inputs sampled at that edge. This covers the mode, the pending flag, the clock enables, the status flags and the single-cycle watchdog pulse. The bench drives inputs on the falling edge and checks outputs on the next falling edge. It then checks again one edge later, for the end of the watchdog pulse and for the hold of a state. Unstable-oscillator waits are checked over several consecutive edges before the stable flag is raised.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [2:0] {
    MODE_NORMAL = 3'd0,
    MODE_SLOW   = 3'd1,
    MODE_SLEEP  = 3'd2,
    MODE_IDLE0  = 3'd3,
    MODE_IDLE1  = 3'd4
  } pwr_mode_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_IDLE0 = 2'd2,
    ST_IDLE1 = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/pmc_req_decode.sv
module pmc_req_decode #(
  parameter int DIV_W        = 3,
  parameter int SLOW_DIV_MAX = 1
) (
  input  logic             hl_sel_i,
  input  logic [DIV_W-1:0] div_sel_i,
  output logic             want_slow_o
);
  localparam logic [DIV_W-1:0] SlowLimit = DIV_W'(SLOW_DIV_MAX);

  always_comb want_slow_o = !hl_sel_i && (div_sel_i <= SlowLimit);
endmodule

// File: rtl/pmc_src_sel.sv
module pmc_src_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic want_slow_i,
  input  logic hosc_stable_i,
  input  logic losc_stable_i,
  output logic on_slow_o,
  output logic pend_o
);
  logic tgt_ready;

  always_comb tgt_ready = want_slow_i ? losc_stable_i : hosc_stable_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_slow_o <= 1'b0;
      pend_o    <= 1'b0;
    end else if (run_i) begin
      if (want_slow_i != on_slow_o) begin
        if (tgt_ready) begin
          on_slow_o <= want_slow_i;
          pend_o    <= 1'b0;
        end else begin
          pend_o    <= 1'b1;
        end
      end else begin
        pend_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pmc_halt_fsm.sv
module pmc_halt_fsm
  import pwr_mode_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       halt_i,
  input  logic       wake_i,
  input  logic       idle_en_i,
  input  logic       sys_on_idle_i,
  input  logic       wdt_timeout_i,
  input  logic       flag_clr_i,
  output pwr_state_e state_o,
  output logic       enter_o,
  output logic       wdt_clr_o,
  output logic       pdf_o,
  output logic       to_o
);
  pwr_state_e state_d;
  logic       enter;

  always_comb begin
    enter   = (state_o == ST_RUN) && halt_i;
    state_d = state_o;
    if (enter) begin
      if (!idle_en_i)         state_d = ST_SLEEP;
      else if (!sys_on_idle_i) state_d = ST_IDLE0;
      else                    state_d = ST_IDLE1;
    end else if (state_o != ST_RUN && wake_i) begin
      state_d = ST_RUN;
    end
  end

  assign enter_o = enter;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o   <= ST_RUN;
      wdt_clr_o <= 1'b0;
      pdf_o     <= 1'b0;
      to_o      <= 1'b0;
    end else begin
      state_o   <= state_d;
      wdt_clr_o <= enter;
      if (enter) begin
        pdf_o <= 1'b1;
        to_o  <= 1'b0;
      end else if (flag_clr_i) begin
        pdf_o <= 1'b0;
        to_o  <= 1'b0;
      end else if (wdt_timeout_i) begin
        to_o  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pmc_clk_gate.sv
module pmc_clk_gate
  import pwr_mode_pkg::*;
(
  input  pwr_state_e state_i,
  input  logic       on_slow_i,
  output logic [2:0] mode_o,
  output logic       sys_src_hi_o,
  output logic       sys_clk_en_o,
  output logic       tb_clk_en_o,
  output logic       sub_clk_en_o
);
  always_comb begin
    unique case (state_i)
      ST_SLEEP: mode_o = MODE_SLEEP;
      ST_IDLE0: mode_o = MODE_IDLE0;
      ST_IDLE1: mode_o = MODE_IDLE1;
      default:  mode_o = on_slow_i ? MODE_SLOW : MODE_NORMAL;
    endcase
    sys_src_hi_o = !on_slow_i;
    sys_clk_en_o = (state_i == ST_RUN) || (state_i == ST_IDLE1);
    tb_clk_en_o  = (state_i != ST_SLEEP);
    sub_clk_en_o = 1'b1;
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int DIV_W        = 3,
  parameter int SLOW_DIV_MAX = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hl_sel_i,
  input  logic [DIV_W-1:0] div_sel_i,
  input  logic             idle_en_i,
  input  logic             sys_on_idle_i,
  input  logic             hosc_stable_i,
  input  logic             losc_stable_i,
  input  logic             halt_i,
  input  logic             wake_i,
  input  logic             wdt_timeout_i,
  input  logic             flag_clr_i,
  output logic [2:0]       mode_o,
  output logic             switch_pend_o,
  output logic             sys_src_hi_o,
  output logic             sys_clk_en_o,
  output logic             tb_clk_en_o,
  output logic             sub_clk_en_o,
  output logic             wdt_clr_o,
  output logic             pdf_o,
  output logic             to_flag_o
);
  logic       want_slow;
  logic       on_slow;
  logic       enter;
  logic       run_sw;
  pwr_state_e state;

  pmc_req_decode #(.DIV_W(DIV_W), .SLOW_DIV_MAX(SLOW_DIV_MAX)) u_dec (
    .hl_sel_i   (hl_sel_i),
    .div_sel_i  (div_sel_i),
    .want_slow_o(want_slow)
  );

  // source switching frozen in low power and on the halt edge
  assign run_sw = (state == ST_RUN) && !enter;

  pmc_src_sel u_src (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run_sw),
    .want_slow_i  (want_slow),
    .hosc_stable_i(hosc_stable_i),
    .losc_stable_i(losc_stable_i),
    .on_slow_o    (on_slow),
    .pend_o       (switch_pend_o)
  );

  pmc_halt_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .halt_i       (halt_i),
    .wake_i       (wake_i),
    .idle_en_i    (idle_en_i),
    .sys_on_idle_i(sys_on_idle_i),
    .wdt_timeout_i(wdt_timeout_i),
    .flag_clr_i   (flag_clr_i),
    .state_o      (state),
    .enter_o      (enter),
    .wdt_clr_o    (wdt_clr_o),
    .pdf_o        (pdf_o),
    .to_o         (to_flag_o)
  );

  pmc_clk_gate u_gate (
    .state_i     (state),
    .on_slow_i   (on_slow),
    .mode_o      (mode_o),
    .sys_src_hi_o(sys_src_hi_o),
    .sys_clk_en_o(sys_clk_en_o),
    .tb_clk_en_o (tb_clk_en_o),
    .sub_clk_en_o(sub_clk_en_o)
  );
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       hosc_stable_i,
  input logic       losc_stable_i,
  input logic       wake_i,
  input logic [2:0] mode_o,
  input logic       sys_src_hi_o,
  input logic       sys_clk_en_o,
  input logic       tb_clk_en_o,
  input logic       sub_clk_en_o,
  input logic       wdt_clr_o,
  input logic       pdf_o,
  input logic       to_flag_o
);
  a_r3_wait_losc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd0 && !losc_stable_i) |=> mode_o != 3'd1);

  a_r4_wait_hosc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd1 && !hosc_stable_i) |=> mode_o != 3'd0);

  a_r5_sleep_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 3'd2 |-> (!sys_clk_en_o && !tb_clk_en_o && sub_clk_en_o));

  a_r6_idle0_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 3'd3 |-> (!sys_clk_en_o && tb_clk_en_o && sub_clk_en_o));

  a_r7_idle1_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 3'd4 |-> (sys_clk_en_o && tb_clk_en_o && sub_clk_en_o));

  a_r8_wdt_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_clr_o |=> !wdt_clr_o);

  a_r8_flags_on_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_clr_o |-> (pdf_o && !to_flag_o && mode_o >= 3'd2));

  a_r10_hold_low_power: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o >= 3'd2 && !wake_i) |=> ($stable(mode_o) && $stable(sys_src_hi_o)));

  a_r9_wake_to_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o >= 3'd2 && wake_i) |=> (mode_o <= 3'd1 && sys_clk_en_o && tb_clk_en_o));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .hosc_stable_i(hosc_stable_i),
  .losc_stable_i(losc_stable_i),
  .wake_i       (wake_i),
  .mode_o       (mode_o),
  .sys_src_hi_o (sys_src_hi_o),
  .sys_clk_en_o (sys_clk_en_o),
  .tb_clk_en_o  (tb_clk_en_o),
  .sub_clk_en_o (sub_clk_en_o),
  .wdt_clr_o    (wdt_clr_o),
  .pdf_o        (pdf_o),
  .to_flag_o    (to_flag_o)
);

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hl_sel = 1'b1;
  logic [2:0] div_sel = 3'd0;
  logic       idle_en = 1'b0, sys_on = 1'b0;
  logic       hosc = 1'b1, losc = 1'b1;
  logic       halt = 1'b0, wake = 1'b0, wdt_to = 1'b0, fclr = 1'b0;
  logic [2:0] mode;
  logic       pend, src_hi, sys_en, tb_en, sub_en, wclr, pdf, tof;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  pwr_mode_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .hl_sel_i(hl_sel), .div_sel_i(div_sel),
    .idle_en_i(idle_en), .sys_on_idle_i(sys_on), .hosc_stable_i(hosc),
    .losc_stable_i(losc), .halt_i(halt), .wake_i(wake),
    .wdt_timeout_i(wdt_to), .flag_clr_i(fclr), .mode_o(mode),
    .switch_pend_o(pend), .sys_src_hi_o(src_hi), .sys_clk_en_o(sys_en),
    .tb_clk_en_o(tb_en), .sub_clk_en_o(sub_en), .wdt_clr_o(wclr),
    .pdf_o(pdf), .to_flag_o(tof)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_run(input int slow);
    hosc = 1'b1; losc = 1'b1;
    hl_sel = (slow != 0) ? 1'b0 : 1'b1;
    div_sel = 3'd0;
    tick();
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1", "mode", mode, 0);
    chk("R1", "src_hi", src_hi, 1);
    chk("R1", "pend", pend, 0);
    chk("R1", "pdf", pdf, 0);
    chk("R1", "to", tof, 0);
    chk("R1", "wdt_clr", wclr, 0);
    chk("R1", "enables", {sys_en, tb_en, sub_en}, 7);
    rst_n = 1'b1;
    tick();

    // R2 decode sweep, both oscillators stable
    for (int h = 0; h < 2; h++) begin
      for (int d = 0; d < 8; d++) begin
        hl_sel = h[0]; div_sel = d[2:0];
        tick();
        chk("R2", "mode", mode, (h == 0 && d < 2) ? 1 : 0);
        chk("R2", "src_hi", src_hi, (h == 0 && d < 2) ? 0 : 1);
      end
    end

    // R3 normal -> slow waits on low-speed stable
    set_run(0);
    losc = 1'b0; hl_sel = 1'b0; div_sel = 3'd1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R3", "mode wait", mode, 0);
      chk("R3", "src_hi wait", src_hi, 1);
      chk("R3", "pend", pend, 1);
    end
    losc = 1'b1;
    tick();
    chk("R3", "mode done", mode, 1);
    chk("R3", "pend done", pend, 0);
    chk("R3", "src_hi done", src_hi, 0);

    // R4 slow -> normal waits on high-speed stable
    hosc = 1'b0; hl_sel = 1'b0; div_sel = 3'd5;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R4", "mode wait", mode, 1);
      chk("R4", "src_hi wait", src_hi, 0);
      chk("R4", "pend", pend, 1);
    end
    hosc = 1'b1;
    tick();
    chk("R4", "mode done", mode, 0);
    chk("R4", "pend done", pend, 0);

    // R5-R11 halt sweep over run mode and both enable bits
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 4; c++) begin
        automatic int exp_mode = (c[0] == 1'b0) ? 2 : ((c[1] == 1'b0) ? 3 : 4);
        set_run(s);
        chk("R2", "run mode", mode, s);
        // R10 wake in run does nothing
        wake = 1'b1; tick(); wake = 1'b0;
        chk("R10", "wake in run", mode, s);
        // R11 timeout sets flag
        wdt_to = 1'b1; tick(); wdt_to = 1'b0;
        chk("R11", "to set", tof, 1);
        idle_en = c[0]; sys_on = c[1];
        halt = 1'b1; tick(); halt = 1'b0;
        chk(exp_mode == 2 ? "R5" : (exp_mode == 3 ? "R6" : "R7"), "mode", mode, exp_mode);
        chk("R5", "sys_en", sys_en, exp_mode == 4 ? 1 : 0);
        chk("R6", "tb_en", tb_en, exp_mode == 2 ? 0 : 1);
        chk("R7", "sub_en", sub_en, 1);
        chk("R8", "wdt_clr", wclr, 1);
        chk("R8", "pdf", pdf, 1);
        chk("R8", "to", tof, 0);
        // R10 ignored inputs in low power
        hl_sel = ~hl_sel; div_sel = 3'd7; halt = 1'b1;
        idle_en = ~idle_en;
        tick(); tick();
        halt = 1'b0;
        chk("R8", "wdt_clr end", wclr, 0);
        chk("R10", "mode held", mode, exp_mode);
        chk("R10", "src held", src_hi, s == 0 ? 1 : 0);
        hl_sel = (s != 0) ? 1'b0 : 1'b1; div_sel = 3'd0;
        wake = 1'b1; tick(); wake = 1'b0;
        chk("R9", "mode", mode, s);
        chk("R9", "enables", {sys_en, tb_en}, 3);
        chk("R9", "pdf kept", pdf, 1);
        fclr = 1'b1; tick(); fclr = 1'b0;
        chk("R11", "pdf cleared", pdf, 0);
      end
    end

    // R11 halt entry beats clear and timeout
    set_run(0);
    idle_en = 1'b0;
    halt = 1'b1; fclr = 1'b1; wdt_to = 1'b1;
    tick();
    halt = 1'b0; fclr = 1'b0; wdt_to = 1'b0;
    chk("R11", "pdf prio", pdf, 1);
    chk("R11", "to prio", tof, 0);
    wake = 1'b1; tick(); wake = 1'b0;
    wdt_to = 1'b1; fclr = 1'b1; tick(); wdt_to = 1'b0; fclr = 1'b0;
    chk("R11", "clr over timeout", {pdf, tof}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule